// File: doc/BRIEF.md
# Vertical Line Counter for Raster Timing

This block tracks the vertical position of the beam in a raster video timing chain. A line-end strobe from the horizontal section advances it one scan line at a time. It keeps a full-range internal line index and derives an 8-bit count for software from that index. It also produces a vertical-blank flag and a one-clock pulse at each frame start. A mode input picks either a 262-line frame or a 313-line frame. The block samples that input only when a frame ends, or during reset.

Eight bits cannot hold 262 or 313 distinct values. For that reason the visible count jumps backward once during blanking. The internal index does not jump. The visible count is a mapping of the index, chosen by the current phase of the frame.

A four-state phase machine holds that phase:
- `PH_ACTIVE`: visible lines.
- `PH_BLANK_PRE`: blanking before the jump.
- `PH_BLANK_POST`: blanking after the jump.
- `PH_TAIL`: the last line of the frame, where blanking has already ended.

Every transition happens on a line-end strobe:
- `PH_ACTIVE` to `PH_BLANK_PRE`: leaving visible count 223.
- `PH_BLANK_PRE` to `PH_BLANK_POST`: leaving the last line before the jump.
- `PH_BLANK_POST` to `PH_TAIL`: leaving the next-to-last line.
- `PH_TAIL` to `PH_ACTIVE`: the frame wraps.

Top module: `vline_counter`

## Requirements
- R1: A synchronous reset, which has priority over a line-end strobe in the same cycle, sets the line index to 0, the visible count to 0, and clears both the blank flag and the frame-start pulse. It also loads the frame mode from `long_mode`.
- R2: The line index rises by exactly one on each clock with `line_end` high, except at the last line. On clocks with `line_end` low, the index and the visible count hold.
- R3: With `long_mode` = 0 latched, a frame is 262 lines: the index runs 0 to 261 and then returns to 0.
- R4: With `long_mode` = 1 latched, a frame is 313 lines: the index runs 0 to 312 and then returns to 0.
- R5: The blank flag is clear on visible counts 0 to 223. It is set from the line whose visible count is 224.
- R6: In the 262-line frame, the visible count equals the index up to 0xEA. The line after it reads 0xE5, and the count then rises by one per line up to 0xFF.
- R7: In the 313-line frame, the visible count rises to 0xFF and wraps through 0x00 to 0x02. The line after it reads 0xCA, and the count then rises by one per line up to 0xFF.
- R8: The blank flag is still set on the line reading 0xFE. It is clear on the final line, which reads 0xFF.
- R9: After the line reading 0xFF, the count returns to 0 with the blank flag clear. `frame_start` is high for exactly the one clock that follows the wrapping strobe.
- R10: A change on `long_mode` during a frame has no effect on that frame. The value on `long_mode` in the clock of the wrapping strobe sets the next frame's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_end | input | 1 | One-clock strobe at the end of each scan line |
| long_mode | input | 1 | Frame mode select: 0 = 262 lines, 1 = 313 lines |
| vcount | output | 8 | Visible line count, with the backward jump |
| line_idx | output | 9 | Internal line index, 0 to frame length minus 1 |
| vblank | output | 1 | Vertical-blank flag |
| frame_start | output | 1 | One-clock pulse when the index returns to 0 |

## Verification
Two functions can fall in the same clock: the frame wrap, which raises `frame_start`, and the sampling of the frame mode. The bench drives a `long_mode` change in the very clock of the wrapping strobe, in both directions. It then checks that the new frame takes the new length while the old frame kept its old length. It also drives a reset together with a line-end strobe, and judges from the outputs in the following clock that the reset won.

// File: rtl/vlc_pkg.sv
`timescale 1ns/1ps
package vlc_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_BLANK_PRE,
        PH_BLANK_POST,
        PH_TAIL
    } vlc_phase_e;
endpackage

// File: rtl/vlc_line_index.sv
`timescale 1ns/1ps
module vlc_line_index #(
    parameter int SHORT_TOTAL    = 262,
    parameter int LONG_TOTAL     = 313,
    parameter int SHORT_LAST_PRE = 234,
    parameter int SHORT_JUMP_TO  = 229,
    parameter int LONG_LAST_PRE  = 258,
    parameter int LONG_JUMP_TO   = 202,
    localparam int IDX_W = $clog2(LONG_TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic             long_mode,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] last_line,
    output logic [IDX_W-1:0] last_pre,
    output logic [IDX_W-1:0] jump_ofs,
    output logic             frame_start
);
    localparam logic [IDX_W-1:0] S_LAST = IDX_W'(SHORT_TOTAL - 1);
    localparam logic [IDX_W-1:0] L_LAST = IDX_W'(LONG_TOTAL - 1);
    localparam logic [IDX_W-1:0] S_PRE  = IDX_W'(SHORT_LAST_PRE);
    localparam logic [IDX_W-1:0] L_PRE  = IDX_W'(LONG_LAST_PRE);
    localparam logic [IDX_W-1:0] S_OFS  = IDX_W'(SHORT_LAST_PRE + 1 - SHORT_JUMP_TO);
    localparam logic [IDX_W-1:0] L_OFS  = IDX_W'(LONG_LAST_PRE + 1 - LONG_JUMP_TO);

    logic mode_q;
    logic at_last;

    always_comb begin
        last_line = mode_q ? L_LAST : S_LAST;
        last_pre  = mode_q ? L_PRE  : S_PRE;
        jump_ofs  = mode_q ? L_OFS  : S_OFS;
        at_last   = (idx == last_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx         <= '0;
            mode_q      <= long_mode;
            frame_start <= 1'b0;
        end else if (line_end) begin
            if (at_last) begin
                idx         <= '0;
                mode_q      <= long_mode;
                frame_start <= 1'b1;
            end else begin
                idx         <= idx + IDX_W'(1);
                frame_start <= 1'b0;
            end
        end else begin
            frame_start <= 1'b0;
        end
    end

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        idx <= last_line);
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (line_end && !at_last) |=> (idx == $past(idx) + IDX_W'(1)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> ($stable(idx) && !frame_start));
    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (line_end && at_last) |=> (idx == '0 && frame_start));
    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !(line_end && at_last) |=> $stable(mode_q));
endmodule

// File: rtl/vlc_phase_fsm.sv
`timescale 1ns/1ps
module vlc_phase_fsm
    import vlc_pkg::*;
#(
    parameter int ACTIVE_LINES = 224,
    parameter int IDX_W        = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last_line,
    input  logic [IDX_W-1:0] last_pre,
    output vlc_phase_e       phase,
    output logic             vblank,
    output logic             jumped
);
    localparam logic [IDX_W-1:0] LAST_ACTIVE = IDX_W'(ACTIVE_LINES - 1);

    vlc_phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        if (line_end) begin
            unique case (phase)
                PH_ACTIVE:     if (idx == LAST_ACTIVE)            phase_nx = PH_BLANK_PRE;
                PH_BLANK_PRE:  if (idx == last_pre)               phase_nx = PH_BLANK_POST;
                PH_BLANK_POST: if (idx == last_line - IDX_W'(1))  phase_nx = PH_TAIL;
                PH_TAIL:                                          phase_nx = PH_ACTIVE;
                default:                                          phase_nx = PH_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_ACTIVE;
        else     phase <= phase_nx;
    end

    always_comb begin
        unique case (phase)
            PH_ACTIVE:     begin vblank = 1'b0; jumped = 1'b0; end
            PH_BLANK_PRE:  begin vblank = 1'b1; jumped = 1'b0; end
            PH_BLANK_POST: begin vblank = 1'b1; jumped = 1'b1; end
            PH_TAIL:       begin vblank = 1'b0; jumped = 1'b1; end
            default:       begin vblank = 1'b0; jumped = 1'b0; end
        endcase
    end

    assert_active_lines_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACTIVE) |-> (idx <= LAST_ACTIVE));
    assert_blank_start_R5: assert property (@(posedge clk) disable iff (rst)
        (idx == IDX_W'(ACTIVE_LINES)) |-> vblank);
    assert_tail_last_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL) |-> (idx == last_line && !vblank));
endmodule

// File: rtl/vlc_count_map.sv
`timescale 1ns/1ps
module vlc_count_map #(
    parameter int IDX_W = 9,
    parameter int VIS_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] jump_ofs,
    input  logic             jumped,
    output logic [VIS_W-1:0] vcount
);
    logic [IDX_W-1:0] shifted;

    always_comb begin
        shifted = idx - jump_ofs;
        vcount  = jumped ? shifted[VIS_W-1:0] : idx[VIS_W-1:0];
    end
endmodule

// File: rtl/vline_counter.sv
`timescale 1ns/1ps
module vline_counter #(
    parameter int ACTIVE_LINES   = 224,
    parameter int SHORT_TOTAL    = 262,
    parameter int LONG_TOTAL     = 313,
    parameter int SHORT_LAST_PRE = 234,
    parameter int SHORT_JUMP_TO  = 229,
    parameter int LONG_LAST_PRE  = 258,
    parameter int LONG_JUMP_TO   = 202,
    parameter int VIS_W          = 8,
    localparam int IDX_W = $clog2(LONG_TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic             long_mode,
    output logic [VIS_W-1:0] vcount,
    output logic [IDX_W-1:0] line_idx,
    output logic             vblank,
    output logic             frame_start
);
    import vlc_pkg::*;

    logic [IDX_W-1:0] last_line, last_pre, jump_ofs;
    vlc_phase_e       phase;
    logic             jumped;

    vlc_line_index #(
        .SHORT_TOTAL(SHORT_TOTAL), .LONG_TOTAL(LONG_TOTAL),
        .SHORT_LAST_PRE(SHORT_LAST_PRE), .SHORT_JUMP_TO(SHORT_JUMP_TO),
        .LONG_LAST_PRE(LONG_LAST_PRE), .LONG_JUMP_TO(LONG_JUMP_TO)
    ) u_index (
        .clk(clk), .rst(rst), .line_end(line_end), .long_mode(long_mode),
        .idx(line_idx), .last_line(last_line), .last_pre(last_pre),
        .jump_ofs(jump_ofs), .frame_start(frame_start)
    );

    vlc_phase_fsm #(.ACTIVE_LINES(ACTIVE_LINES), .IDX_W(IDX_W)) u_phase (
        .clk(clk), .rst(rst), .line_end(line_end), .idx(line_idx),
        .last_line(last_line), .last_pre(last_pre),
        .phase(phase), .vblank(vblank), .jumped(jumped)
    );

    vlc_count_map #(.IDX_W(IDX_W), .VIS_W(VIS_W)) u_map (
        .idx(line_idx), .jump_ofs(jump_ofs), .jumped(jumped), .vcount(vcount)
    );

    assert_final_ff_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (vcount == '0 && !vblank && $past(vcount) == '1));
    assert_fe_blank_R8: assert property (@(posedge clk) disable iff (rst)
        (jumped && vcount == VIS_W'(254)) |-> vblank);
endmodule

// File: tb/vline_counter_test.sv
`timescale 1ns/1ps
module vline_counter_test;
    localparam int IW = 9;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [7:0]    vc;
        logic          vb;
        logic          fs;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_end = 1'b0;
    logic long_mode = 1'b0;
    logic [7:0]    vcount;
    logic [IW-1:0] line_idx;
    logic          vblank, frame_start;

    vline_counter uut (
        .clk(clk), .rst(rst), .line_end(line_end), .long_mode(long_mode),
        .vcount(vcount), .line_idx(line_idx), .vblank(vblank),
        .frame_start(frame_start)
    );

    always #2.5 clk = ~clk;

    exp_t  q[$];
    string tq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    int m_idx = 0;
    bit m_mode = 0;
    bit m_fs = 0;

    function automatic int frame_len(bit md);
        return md ? 313 : 262;
    endfunction

    function automatic logic [7:0] exp_vc(int i, bit md);
        if (!md) begin
            if (i <= 8'hEA) return 8'(i);
            return 8'(8'hE5 + (i - 235));
        end
        if (i < 256) return 8'(i);
        if (i < 259) return 8'(i - 256);
        return 8'(8'hCA + (i - 259));
    endfunction

    task automatic push_exp();
        exp_t e;
        string t;
        int last;
        last = frame_len(m_mode) - 1;
        e.idx = IW'(m_idx);
        e.vc  = exp_vc(m_idx, m_mode);
        e.vb  = (m_idx >= 224) && (m_idx != last);
        e.fs  = m_fs;
        t = cur_req;
        if (m_fs) t = "R9";
        else if (m_idx == last) t = "R8";
        else if (m_idx == last - 1) t = "R8";
        else if (m_idx == 224) t = "R5";
        else if (!m_mode && m_idx > 234) t = "R6";
        else if (m_mode && m_idx > 255) t = "R7";
        q.push_back(e);
        tq.push_back(t);
    endtask

    task automatic cyc(bit le, bit lm);
        @(negedge clk);
        rst = 1'b0;
        line_end = le;
        long_mode = lm;
        if (le) begin
            if (m_idx == frame_len(m_mode) - 1) begin
                m_idx = 0; m_mode = lm; m_fs = 1;
            end else begin
                m_idx = m_idx + 1; m_fs = 0;
            end
        end else begin
            m_fs = 0;
        end
        push_exp();
    endtask

    task automatic do_reset(bit lm, bit le);
        @(negedge clk);
        rst = 1'b1;
        line_end = le;
        long_mode = lm;
        m_idx = 0; m_mode = lm; m_fs = 0;
        push_exp();
    endtask

    task automatic run_lines(int n, bit lm);
        for (int k = 0; k < n; k++) cyc(1'b1, lm);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t  e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            checks++;
            if (line_idx !== e.idx || vcount !== e.vc || vblank !== e.vb || frame_start !== e.fs) begin
                errors++;
                $display("FAIL %s: actual idx=%0d vc=%02h vb=%b fs=%b expected idx=%0d vc=%02h vb=%b fs=%b",
                         t, line_idx, vcount, vblank, frame_start, e.idx, e.vc, e.vb, e.fs);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        do_reset(1'b0, 1'b0);
        do_reset(1'b0, 1'b0);
        cur_req = "R2";
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
            cyc(1'b0, 1'b0);
        end
        cur_req = "R3";
        run_lines(262 - 6 - 1, 1'b0);
        cur_req = "R9";
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        cur_req = "R10";
        run_lines(100, 1'b0);
        run_lines(161, 1'b1);
        cur_req = "R10";
        cyc(1'b1, 1'b1);
        cur_req = "R4";
        run_lines(150, 1'b1);
        cur_req = "R10";
        run_lines(162, 1'b0);
        cyc(1'b1, 1'b0);
        cur_req = "R3";
        run_lines(261, 1'b1);
        cur_req = "R10";
        cyc(1'b1, 1'b1);
        cur_req = "R4";
        run_lines(313, 1'b1);
        cur_req = "R7";
        run_lines(40, 1'b1);
        cur_req = "R1";
        do_reset(1'b0, 1'b1);
        cur_req = "R2";
        cyc(1'b0, 1'b0);
        cur_req = "R3";
        run_lines(262, 1'b0);
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule